// File: doc/BRIEF.md
# Expansion RAM Sideload Controller

This block sits between a cartridge SRAM, the host CPU bus and a local microcontroller. It lets the microcontroller fill the SRAM at its own pace while the host CPU waits. The host starts a transfer by reading a status register in its I/O window. It then keeps reading that register, which stays nonzero until the transfer has finished.

While a transfer runs, the SRAM is cut off from the host. Its address comes from an internal counter, and its data comes from the microcontroller's byte port. Each byte strobe writes one byte and moves the counter on by one. When the microcontroller reports completion, the SRAM is handed back to the host.

The microcontroller sets the start address with a parallel load. It can read a sticky flag that records whether the counter wrapped past the top of memory.

Top module: `sideload_ctrl`

## Requirements
- R1: When idle, a host read of the status register (`host_reg_en`=1, `host_we`=0) returns 0x01 in that same cycle and starts a transfer from the next clock. While the transfer runs, every status read returns 0x01.
- R2: `mcu_done` during a transfer ends isolation from the next cycle. The first status read after that returns 0x00 and starts nothing. The next status read while idle starts a new transfer.
- R3: While a transfer runs, host reads of the memory window return 0xFF. Host memory accesses never assert `sram_ce_n`, and host writes never reach the SRAM.
- R4: `mcu_addr_ld` loads the counter with `mcu_addr` in any state and clears the overflow flag. A load wins over a step in the same cycle.
- R5: During a transfer, each rising edge of `mcu_strobe` gives exactly one cycle with `sram_ce_n`=0 and `sram_we_n`=0. In that cycle `sram_addr` is the counter and `sram_wdata` is `mcu_data`, and the counter advances by one on the next clock. A strobe held high for several cycles still writes only once.
- R6: Strobes outside a transfer write nothing and leave the counter unchanged.
- R7: Stepping the counter from all ones wraps it to zero and sets `mcu_ovf`. The flag stays set until the next address load or reset.
- R8: Outside a transfer the SRAM follows the host. `sram_addr` equals `host_addr`, `sram_ce_n` is the inverse of `host_mem_en`, a host write pulls `sram_we_n` low, and host memory reads return `sram_rdata`.
- R9: After reset the block is idle, the counter is zero, `mcu_ovf` is 0, and the SRAM enables are high while the host is quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | ADDR_W | Host address into the expansion memory |
| host_mem_en | input | 1 | Host access to an expansion memory window |
| host_reg_en | input | 1 | Host access to the status register |
| host_we | input | 1 | Host access is a write |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data returned to the host |
| mcu_addr_ld | input | 1 | Load the start address |
| mcu_addr | input | ADDR_W | Start address value |
| mcu_data | input | DATA_W | Byte to be written |
| mcu_strobe | input | 1 | Byte strobe; its rising edge writes |
| mcu_done | input | 1 | Transfer complete |
| mcu_ovf | output | 1 | Sticky counter wrap flag |
| sram_addr | output | ADDR_W | SRAM address |
| sram_wdata | output | DATA_W | SRAM write data |
| sram_rdata | input | DATA_W | SRAM read data |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |

## Verification
The bench builds the block with its default parameters: a 21-bit address and 8-bit data. The wrap at the top of the 2 MB space is reached by loading the start address 0x1FFFFF and writing two bytes, so the full counter width is exercised without millions of strobes. The SRAM model keeps only 256 bytes, indexed by the low address byte. The test addresses are chosen so that their low bytes are distinct, except where the wrap test deliberately lands on 0xFF and then 0x00.

// File: rtl/sideload_pkg.sv
package sideload_pkg;
  typedef enum logic [1:0] {
    SL_IDLE  = 2'd0,
    SL_BUSY  = 2'd1,
    SL_DRAIN = 2'd2
  } sl_state_e;

  localparam logic [7:0] STAT_BUSY  = 8'h01;
  localparam logic [7:0] STAT_CLEAR = 8'h00;
endpackage

// File: rtl/sl_handshake.sv
module sl_handshake
  import sideload_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_rd,
  input  logic       done,
  output logic       iso,
  output logic [7:0] status
);
  sl_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      SL_IDLE:  if (reg_rd) state_nx = SL_BUSY;
      SL_BUSY:  if (done)   state_nx = SL_DRAIN;
      SL_DRAIN: if (reg_rd) state_nx = SL_IDLE;
      default:              state_nx = SL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= SL_IDLE;
    else        state <= state_nx;
  end

  assign iso    = (state == SL_BUSY);
  assign status = ((state == SL_BUSY) || (state == SL_IDLE && reg_rd)) ? STAT_BUSY : STAT_CLEAR;

  // R1: a transfer stays open until the microcontroller finishes it
  a_r1_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (iso && !done) |=> iso);
  // R2: completion releases isolation on the following cycle
  a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
    (iso && done) |=> !iso);
  // R2: the drain read never restarts a transfer
  a_r2_drain_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SL_DRAIN) |=> !iso);
endmodule

// File: rtl/sl_addr_counter.sv
module sl_addr_counter #(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  output logic [ADDR_W-1:0] count,
  output logic              ovf
);
  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

  function automatic logic [ADDR_W:0] bump(input logic [ADDR_W-1:0] a);
    return {1'b0, a} + {{ADDR_W{1'b0}}, 1'b1};
  endfunction

  logic [ADDR_W:0] nxt;
  assign nxt = bump(count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (load) begin
      count <= load_val;
      ovf   <= 1'b0;
    end else if (step) begin
      count <= nxt[ADDR_W-1:0];
      if (nxt[ADDR_W]) ovf <= 1'b1;
    end
  end

  // R4: a load places the value and clears the flag
  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)) && !ovf);
  // R6: no step and no load means no movement
  a_r6_still: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(count));
  // R7: the overflow flag is sticky
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !load) |=> ovf);
  // R7: stepping from the top sets the flag and lands on zero
  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && count == TOP) |=> (ovf && count == '0));
endmodule

// File: rtl/sl_strobe_gate.sv
module sl_strobe_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic enable,
  output logic fire
);
  logic strobe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe;
  end

  assign fire = enable && strobe && !strobe_q;

  // R5: a held strobe fires once
  a_r5_single: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
  // R6: nothing fires outside a transfer
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !fire);
endmodule

// File: rtl/sl_bus_mux.sv
module sl_bus_mux #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 8
) (
  input  logic              iso,
  input  logic              fire,
  input  logic [ADDR_W-1:0] count,
  input  logic [DATA_W-1:0] mcu_data,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_mem_en,
  input  logic              host_reg_en,
  input  logic              host_we,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [7:0]        status,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_wdata,
  output logic              sram_ce_n,
  output logic              sram_we_n
);
  localparam logic [DATA_W-1:0] FLOAT = {DATA_W{1'b1}};

  always_comb begin
    if (iso) begin
      sram_addr  = count;
      sram_wdata = mcu_data;
      sram_ce_n  = !fire;
      sram_we_n  = !fire;
    end else begin
      sram_addr  = host_addr;
      sram_wdata = host_wdata;
      sram_ce_n  = !host_mem_en;
      sram_we_n  = !(host_mem_en && host_we);
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_reg_en)      host_rdata = DATA_W'(status);
    else if (host_mem_en) host_rdata = iso ? FLOAT : sram_rdata;
  end
endmodule

// File: rtl/sideload_ctrl.sv
module sideload_ctrl #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_mem_en,
  input  logic              host_reg_en,
  input  logic              host_we,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              mcu_addr_ld,
  input  logic [ADDR_W-1:0] mcu_addr,
  input  logic [DATA_W-1:0] mcu_data,
  input  logic              mcu_strobe,
  input  logic              mcu_done,
  output logic              mcu_ovf,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_wdata,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic              sram_ce_n,
  output logic              sram_we_n
);
  logic              iso;
  logic              fire;
  logic              reg_rd;
  logic [7:0]        status;
  logic [ADDR_W-1:0] count;

  assign reg_rd = host_reg_en && !host_we;

  sl_handshake u_hs (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .done(mcu_done),
    .iso(iso), .status(status)
  );

  sl_strobe_gate u_gate (
    .clk(clk), .rst_n(rst_n), .strobe(mcu_strobe), .enable(iso), .fire(fire)
  );

  sl_addr_counter #(.ADDR_W(ADDR_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(mcu_addr_ld), .load_val(mcu_addr),
    .step(fire), .count(count), .ovf(mcu_ovf)
  );

  sl_bus_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .iso(iso), .fire(fire), .count(count), .mcu_data(mcu_data),
    .host_addr(host_addr), .host_mem_en(host_mem_en), .host_reg_en(host_reg_en),
    .host_we(host_we), .host_wdata(host_wdata), .status(status),
    .sram_rdata(sram_rdata), .host_rdata(host_rdata), .sram_addr(sram_addr),
    .sram_wdata(sram_wdata), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n)
  );

  // R3: host traffic never enables the SRAM during a transfer
  a_r3_no_host_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (iso && !fire) |-> sram_ce_n);
  // R5: a write step moves the counter by exactly one
  a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !mcu_addr_ld) |=> (count == $past(count) + 1'b1));
  // R5: the write pulse targets the counter
  a_r5_addr: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (!sram_we_n && sram_addr == count));
endmodule

// File: tb/sideload_ctrl_tb_top.sv
module sideload_ctrl_tb_top;
  localparam int AW = 21;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic          host_mem_en = 1'b0, host_reg_en = 1'b0, host_we = 1'b0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic          mcu_addr_ld = 1'b0;
  logic [AW-1:0] mcu_addr = '0;
  logic [DW-1:0] mcu_data = '0;
  logic          mcu_strobe = 1'b0, mcu_done = 1'b0;
  logic          mcu_ovf;
  logic [AW-1:0] sram_addr;
  logic [DW-1:0] sram_wdata, sram_rdata;
  logic          sram_ce_n, sram_we_n;

  int checks = 0;
  int fails  = 0;
  int writes = 0;
  logic [7:0] mem [256];

  always #10 clk = ~clk;

  sideload_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_mem_en(host_mem_en),
    .host_reg_en(host_reg_en), .host_we(host_we), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .mcu_addr_ld(mcu_addr_ld), .mcu_addr(mcu_addr),
    .mcu_data(mcu_data), .mcu_strobe(mcu_strobe), .mcu_done(mcu_done),
    .mcu_ovf(mcu_ovf), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
    .sram_rdata(sram_rdata), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n)
  );

  // SRAM model: 256 bytes indexed by the low address byte
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 256; k++) mem[k] <= 8'h00;
    end else if (!sram_ce_n && !sram_we_n) begin
      mem[sram_addr[7:0]] <= sram_wdata;
      writes <= writes + 1;
    end
  end
  assign sram_rdata = mem[sram_addr[7:0]];

  localparam int NV = 8;
  localparam logic [7:0] VEC_DATA [NV] = '{8'h11, 8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h7E, 8'hC3, 8'h42};
  localparam int         VEC_HOLD [NV] = '{1, 2, 1, 3, 1, 4, 1, 2};
  localparam logic [AW-1:0] START = 21'h000140;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_read(output logic [7:0] d);
    host_reg_en = 1'b1; host_we = 1'b0;
    #1 d = host_rdata;
    @(negedge clk);
    host_reg_en = 1'b0;
  endtask

  task automatic mem_access(input logic [AW-1:0] a, input bit wr, input logic [7:0] wd,
                            output logic [7:0] d, output logic ce_n);
    host_addr = a; host_mem_en = 1'b1; host_we = wr; host_wdata = wd;
    #1 d = host_rdata; ce_n = sram_ce_n;
    @(negedge clk);
    host_mem_en = 1'b0; host_we = 1'b0;
  endtask

  task automatic load_addr(input logic [AW-1:0] a);
    mcu_addr = a; mcu_addr_ld = 1'b1;
    @(negedge clk);
    mcu_addr_ld = 1'b0;
  endtask

  task automatic strobe(input logic [7:0] d, input int hold);
    mcu_data = d; mcu_strobe = 1'b1;
    repeat (hold) @(negedge clk);
    mcu_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_xfer();
    mcu_done = 1'b1;
    @(negedge clk);
    mcu_done = 1'b0;
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic ce;
    int w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state
    #1;
    chk(sram_ce_n && sram_we_n, "R9 enables idle", {sram_ce_n, sram_we_n}, 3);
    chk(mcu_ovf == 1'b0, "R9 ovf clear", mcu_ovf, 0);
    @(negedge clk);

    // R8: host owns the SRAM when idle
    mem_access(21'h000060, 1'b1, 8'h5A, d, ce);
    chk(ce == 1'b0, "R8 host ce", ce, 0);
    mem_access(21'h000060, 1'b0, 8'h00, d, ce);
    chk(d == 8'h5A, "R8 host readback", d, 8'h5A);

    // R6: strobe while idle is ignored
    load_addr(START);
    w0 = writes;
    strobe(8'hEE, 1);
    chk(writes == w0, "R6 idle strobe no write", writes, w0);

    // R1: trigger read
    reg_read(d);
    chk(d == 8'h01, "R1 trigger status", d, 8'h01);
    reg_read(d);
    chk(d == 8'h01, "R1 busy status", d, 8'h01);

    // R5: vector walk, one write per strobe, consecutive addresses
    for (int i = 0; i < NV; i++) begin
      w0 = writes;
      strobe(VEC_DATA[i], VEC_HOLD[i]);
      chk(writes == w0 + 1, "R5 one pulse per strobe", writes, w0 + 1);
      chk(mem[8'h40 + i] == VEC_DATA[i], "R5 byte placed", mem[8'h40 + i], VEC_DATA[i]);
    end
    chk(mem[8'h48] == 8'h00, "R6 idle strobe left counter", mem[8'h48], 0);

    // R3: host isolated during transfer
    mem_access(21'h000140, 1'b0, 8'h00, d, ce);
    chk(d == 8'hFF, "R3 read floats", d, 8'hFF);
    chk(ce == 1'b1, "R3 no ce on read", ce, 1);
    w0 = writes;
    mem_access(21'h000050, 1'b1, 8'h99, d, ce);
    chk(ce == 1'b1 && writes == w0, "R3 host write blocked", writes, w0);
    chk(mem[8'h50] == 8'h00, "R3 memory untouched", mem[8'h50], 0);

    // R2: completion and drain
    finish_xfer();
    mem_access(21'h000141, 1'b0, 8'h00, d, ce);
    chk(d == 8'hA5, "R2 reconnected read", d, 8'hA5);
    reg_read(d);
    chk(d == 8'h00, "R2 drain status", d, 0);
    mem_access(21'h000142, 1'b0, 8'h00, d, ce);
    chk(d == 8'h3C, "R2 drain did not restart", d, 8'h3C);
    reg_read(d);
    chk(d == 8'h01, "R2 restart status", d, 8'h01);

    // R7: wrap at the top of memory
    load_addr(21'h1FFFFF);
    chk(mcu_ovf == 1'b0, "R4 load clears ovf", mcu_ovf, 0);
    strobe(8'hB1, 1);
    chk(mem[8'hFF] == 8'hB1, "R7 top byte", mem[8'hFF], 8'hB1);
    chk(mcu_ovf == 1'b1, "R7 ovf set", mcu_ovf, 1);
    strobe(8'hB2, 1);
    chk(mem[8'h00] == 8'hB2, "R7 wrapped to zero", mem[8'h00], 8'hB2);
    finish_xfer();
    reg_read(d);
    chk(mcu_ovf == 1'b1, "R7 ovf sticky", mcu_ovf, 1);

    // R4: load clears and sets a new start
    load_addr(21'h000180);
    chk(mcu_ovf == 1'b0, "R4 ovf cleared", mcu_ovf, 0);
    reg_read(d);
    strobe(8'h6D, 2);
    chk(mem[8'h80] == 8'h6D, "R4 new start used", mem[8'h80], 8'h6D);
    finish_xfer();
    reg_read(d);
    chk(d == 8'h00, "R2 second drain", d, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule